// File: doc/BRIEF.md
# ADC Offset and Gain Calibration Controller

This block runs a calibration pass over the converter channels that are enabled and keeps the resulting corrections in a small internal table. Each table entry belongs to a setting combination, meaning a gain code together with an offset code, and not to a channel. A pulse on `cal_start` takes a snapshot of the channel enable mask and of every channel's setting. The controller then requests one measurement for each distinct setting it found. The analog side is a stub here: a request/acknowledge handshake returns one signed correction word per request. When the last correction is stored, a sticky end-of-calibration flag is raised. An interrupt line follows that flag while the interrupt enable is set.

During normal operation every raw conversion result passes through the block. The controller looks up the entry for the channel's current setting and subtracts the stored correction. It clamps the difference to the unsigned result range and delivers it one cycle later. When no valid entry exists for the setting, the raw value passes through unchanged and an "uncalibrated" flag marks the result. A soft reset aborts any pass, drops every table entry and clears the flag. A channel that moves to a setting which is already calibrated gets corrected results at once, with no new pass.

Top module: `adc_autocal`

## Requirements
- R1: A `cal_start` pulse sampled while no pass runs starts a pass, and `cal_busy` is high on the next cycle. `cal_busy` stays high until the pass ends.
- R2: A pass issues exactly one measurement request for each distinct setting key among the channels it covers, in ascending key order. The key of a channel is `{gain code, offset code}`, with the gain code in the upper bits. `meas_req` and `meas_key` hold steady until `meas_ack`. A pass with no enabled channel requests nothing and completes.
- R3: A pass covers only the channels enabled on the cycle `cal_start` is sampled. Changing `ch_enable` during the pass adds no requests.
- R4: When a pass completes, `eoc_flag` is set on the next cycle and stays set until a `stat_read` pulse clears it. If completion and `stat_read` fall in the same cycle, the flag is set.
- R5: `eoc_irq` is high exactly while `eoc_flag` and `eoc_irq_en` are both high.
- R6: A `cal_start` pulse while a pass runs is ignored. The running pass keeps its request sequence and no second pass follows.
- R7: For a setting with a valid entry, the result is raw minus the stored correction. The correction is read as DATA_W-bit two's complement, and the result is clamped to 0 .. 2^DATA_W-1 with `res_uncal` = 0.
- R8: For a setting with no valid entry, `res_data` equals the raw input and `res_uncal` = 1.
- R9: Table entries are keyed by setting, so any channel whose current setting was calibrated gets corrected results, even if that channel was not covered by the pass.
- R10: `soft_reset` aborts a running pass, drops every table entry and clears `eoc_flag`. No request is left pending afterwards.
- R11: Each `conv_valid` cycle produces exactly one `res_valid` cycle, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_reset | input | 1 | Pulse: abort pass, invalidate table, clear flag |
| cal_start | input | 1 | Pulse: start a calibration pass |
| stat_read | input | 1 | Pulse: status read, clears `eoc_flag` |
| eoc_irq_en | input | 1 | Interrupt enable for end of calibration |
| ch_enable | input | NUM_CH | Channel enable mask |
| ch_gain | input | NUM_CH*GAIN_W | Per-channel gain codes, channel 0 in the low bits |
| ch_offs | input | NUM_CH*OFFS_W | Per-channel offset codes, channel 0 in the low bits |
| cal_busy | output | 1 | A pass is running |
| eoc_flag | output | 1 | Sticky end-of-calibration flag |
| eoc_irq | output | 1 | End-of-calibration interrupt |
| meas_req | output | 1 | Measurement request to the analog stub |
| meas_key | output | KEY_W | Setting key being measured |
| meas_ack | input | 1 | One-cycle acknowledge carrying the correction |
| meas_corr | input | DATA_W | Signed correction word returned with the acknowledge |
| conv_valid | input | 1 | Raw conversion result valid |
| conv_ch | input | CH_W | Channel of the raw result |
| conv_raw | input | DATA_W | Raw conversion result |
| res_valid | output | 1 | Corrected result valid |
| res_data | output | DATA_W | Corrected (or passed-through) result |
| res_uncal | output | 1 | Result had no calibration entry |

## Verification
The bench builds the block with four channels, a two-bit gain code, a one-bit offset code and 12-bit data. That gives eight setting keys, so two channels can share a setting while a third uses a setting no pass has covered. Chosen correction words of -2048 and 100 drive the clamp to both rails. The bench stalls its measurement stub for two cycles. This holds a pass open long enough to change the enable mask, issue a second start and assert a soft reset while a request is pending.

// File: rtl/adc_autocal_pkg.sv
// Package: shared types for the ADC calibration controller.
// Assumes: nothing beyond standard SystemVerilog.
package adc_autocal_pkg;

    // Pass sequencer states
    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,
        CAL_PICK = 2'd1,
        CAL_WAIT = 2'd2
    } cal_state_t;

endpackage

// File: rtl/adc_autocal_seq.sv
// Module: adc_autocal_seq
// Runs one calibration pass. On a start pulse it snapshots which setting
// keys are used by enabled channels into a pending map. It then walks that
// map lowest key first and issues one measurement request per key.
// Assumes: meas_ack is a single-cycle pulse that is only meaningful while
// meas_req is high; soft_reset has priority over everything.
module adc_autocal_seq
    import adc_autocal_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int KEY_W  = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           soft_reset,
    input  logic                           cal_start,
    input  logic [NUM_CH-1:0]              ch_en,
    input  logic [NUM_CH-1:0][KEY_W-1:0]   ch_key,
    input  logic                           meas_ack,
    output logic                           busy,
    output logic                           meas_req,
    output logic [KEY_W-1:0]               meas_key,
    output logic                           wr_en,
    output logic                           done
);

    localparam int NKEY = 1 << KEY_W;

    cal_state_t        state;
    logic [NKEY-1:0]   pend;
    logic [NKEY-1:0]   need_map;
    logic [KEY_W-1:0]  cur_key;
    logic [KEY_W-1:0]  nxt_key;
    logic              have_key;

    // Mark every key used by at least one enabled channel
    always_comb begin
        need_map = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_en[c]) need_map[ch_key[c]] = 1'b1;
        end
    end

    // Find the lowest pending key
    always_comb begin
        nxt_key  = '0;
        have_key = 1'b0;
        for (int k = NKEY - 1; k >= 0; k--) begin
            if (pend[k]) begin
                nxt_key  = KEY_W'(k);
                have_key = 1'b1;
            end
        end
    end

    // Pass state machine and pending-key bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || soft_reset) begin
            state   <= CAL_IDLE;
            pend    <= '0;
            cur_key <= '0;
        end else begin
            case (state)
                CAL_IDLE: begin
                    if (cal_start) begin
                        pend  <= need_map;
                        state <= CAL_PICK;
                    end
                end
                CAL_PICK: begin
                    if (have_key) begin
                        cur_key <= nxt_key;
                        state   <= CAL_WAIT;
                    end else begin
                        state <= CAL_IDLE;
                    end
                end
                CAL_WAIT: begin
                    if (meas_ack) begin
                        pend[cur_key] <= 1'b0;
                        state         <= CAL_PICK;
                    end
                end
                default: state <= CAL_IDLE;
            endcase
        end
    end

    // Status and handshake outputs derived from state
    always_comb begin
        busy     = (state != CAL_IDLE);
        meas_req = (state == CAL_WAIT);
        meas_key = cur_key;
        wr_en    = (state == CAL_WAIT) && meas_ack && !soft_reset;
        done     = (state == CAL_PICK) && !have_key && !soft_reset;
    end

    // R1: an accepted start makes the block busy on the next cycle
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cal_start && !soft_reset) |=> busy);

    // R2: request and key stay stable until acknowledged
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && !meas_ack && !soft_reset) |=> (meas_req && $stable(meas_key)));

    // R3: the pending map only shrinks on an acknowledge once a pass runs
    p_snapshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAL_WAIT && !meas_ack && !soft_reset) |=> $stable(pend));

    // R6: a start during a running pass does not restart it
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAL_WAIT && cal_start && !meas_ack && !soft_reset)
        |=> (state == CAL_WAIT && $stable(pend)));

    // R10: soft reset leaves no pending request
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |=> (!meas_req && pend == '0));

endmodule

// File: rtl/adc_autocal_table.sv
// Module: adc_autocal_table
// Correction storage: one signed word and one valid bit per setting key.
// The read is combinational. A write lands at the clock edge.
// Assumes: wr_en is already gated against soft_reset by the sequencer;
// this module also gives soft_reset priority.
module adc_autocal_table #(
    parameter int KEY_W  = 3,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_reset,
    input  logic              wr_en,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [DATA_W-1:0] wr_corr,
    input  logic [KEY_W-1:0]  rd_key,
    output logic [DATA_W-1:0] rd_corr,
    output logic              rd_valid
);

    localparam int NKEY = 1 << KEY_W;

    logic [DATA_W-1:0] corr_q [NKEY];
    logic [NKEY-1:0]   valid_q;

    // One storage slot per key
    for (genvar k = 0; k < NKEY; k++) begin : g_slot
        // Capture the correction word for this key
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                corr_q[k] <= '0;
            end else if (wr_en && !soft_reset && wr_key == KEY_W'(k)) begin
                corr_q[k] <= wr_corr;
            end
        end
    end

    // Valid bits: set on write, cleared by any reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_reset) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_key] <= 1'b1;
        end
    end

    // Read port
    always_comb begin
        rd_corr  = corr_q[rd_key];
        rd_valid = valid_q[rd_key];
    end

    // R10: soft reset empties the table
    p_table_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |=> (valid_q == '0));

    // R2: a write always leaves its key valid
    p_write_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_reset) |=> valid_q[$past(wr_key)]);

endmodule

// File: rtl/adc_autocal_apply.sv
// Module: adc_autocal_apply
// Applies the stored correction to each raw result. It subtracts the signed
// correction, clamps to the unsigned range and registers the output.
// Without a valid entry the raw value passes through and is flagged.
// Assumes: the table read for conv_key is presented in the same cycle.
module adc_autocal_apply #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_raw,
    input  logic [DATA_W-1:0] corr,
    input  logic              corr_valid,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_uncal
);

    localparam int EW = DATA_W + 2;
    localparam logic signed [EW-1:0] SAT_HI = EW'((1 << DATA_W) - 1);

    logic signed [EW-1:0] diff;
    logic [DATA_W-1:0]    clamped;

    // Signed difference and clamp to the output range
    always_comb begin
        diff = $signed({2'b00, conv_raw}) - $signed({{2{corr[DATA_W-1]}}, corr});
        if (diff < 0) begin
            clamped = '0;
        end else if (diff > SAT_HI) begin
            clamped = '1;
        end else begin
            clamped = diff[DATA_W-1:0];
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_uncal <= 1'b0;
        end else begin
            res_valid <= conv_valid;
            if (conv_valid) begin
                res_data  <= corr_valid ? clamped : conv_raw;
                res_uncal <= !corr_valid;
            end
        end
    end

    // R11: one result per input, one cycle later
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> res_valid);
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_valid |=> !res_valid);

    // R8: an uncalibrated result is the raw input unchanged
    p_uncal_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && !corr_valid) |=> (res_uncal && res_data == $past(conv_raw)));

endmodule

// File: rtl/adc_autocal.sv
// Module: adc_autocal (top)
// ADC calibration controller. It builds per-channel setting keys, runs
// the pass sequencer, stores corrections per key, corrects the result
// stream and keeps the sticky end-of-calibration flag and interrupt.
// Assumes: NUM_CH >= 2; all control inputs are single-cycle pulses
// except eoc_irq_en, ch_enable and the setting codes.
module adc_autocal #(
    parameter int NUM_CH = 8,
    parameter int GAIN_W = 2,
    parameter int OFFS_W = 1,
    parameter int DATA_W = 12,
    localparam int KEY_W = GAIN_W + OFFS_W,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_reset,
    input  logic                     cal_start,
    input  logic                     stat_read,
    input  logic                     eoc_irq_en,
    input  logic [NUM_CH-1:0]        ch_enable,
    input  logic [NUM_CH*GAIN_W-1:0] ch_gain,
    input  logic [NUM_CH*OFFS_W-1:0] ch_offs,
    output logic                     cal_busy,
    output logic                     eoc_flag,
    output logic                     eoc_irq,
    output logic                     meas_req,
    output logic [KEY_W-1:0]         meas_key,
    input  logic                     meas_ack,
    input  logic [DATA_W-1:0]        meas_corr,
    input  logic                     conv_valid,
    input  logic [CH_W-1:0]          conv_ch,
    input  logic [DATA_W-1:0]        conv_raw,
    output logic                     res_valid,
    output logic [DATA_W-1:0]        res_data,
    output logic                     res_uncal
);

    logic [NUM_CH-1:0][KEY_W-1:0] ch_key;
    logic                         tbl_wr;
    logic                         pass_done;
    logic [KEY_W-1:0]             conv_key;
    logic [DATA_W-1:0]            tbl_corr;
    logic                         tbl_valid;

    // Per-channel key: gain code above offset code
    for (genvar c = 0; c < NUM_CH; c++) begin : g_key
        assign ch_key[c] = {ch_gain[c*GAIN_W +: GAIN_W], ch_offs[c*OFFS_W +: OFFS_W]};
    end

    // Key of the channel whose result is arriving
    assign conv_key = ch_key[conv_ch];

    adc_autocal_seq #(
        .NUM_CH (NUM_CH),
        .KEY_W  (KEY_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_reset (soft_reset),
        .cal_start  (cal_start),
        .ch_en      (ch_enable),
        .ch_key     (ch_key),
        .meas_ack   (meas_ack),
        .busy       (cal_busy),
        .meas_req   (meas_req),
        .meas_key   (meas_key),
        .wr_en      (tbl_wr),
        .done       (pass_done)
    );

    adc_autocal_table #(
        .KEY_W  (KEY_W),
        .DATA_W (DATA_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_reset (soft_reset),
        .wr_en      (tbl_wr),
        .wr_key     (meas_key),
        .wr_corr    (meas_corr),
        .rd_key     (conv_key),
        .rd_corr    (tbl_corr),
        .rd_valid   (tbl_valid)
    );

    adc_autocal_apply #(
        .DATA_W (DATA_W)
    ) u_apply (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_valid (conv_valid),
        .conv_raw   (conv_raw),
        .corr       (tbl_corr),
        .corr_valid (tbl_valid),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .res_uncal  (res_uncal)
    );

    // Sticky end-of-calibration flag; completion wins over a read
    always_ff @(posedge clk) begin
        if (!rst_n || soft_reset) begin
            eoc_flag <= 1'b0;
        end else if (pass_done) begin
            eoc_flag <= 1'b1;
        end else if (stat_read) begin
            eoc_flag <= 1'b0;
        end
    end

    // Interrupt line gated by its enable
    assign eoc_irq = eoc_flag && eoc_irq_en;

    // R4: completion sets the flag on the next cycle
    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> eoc_flag);

    // R4: the flag holds until read or soft reset
    p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_flag && !stat_read && !soft_reset) |=> eoc_flag);

    // R5: a newly raised flag reaches the interrupt when enabled
    p_irq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(eoc_flag) && eoc_irq_en) |-> eoc_irq);

    // R10: soft reset clears the flag and the busy state
    p_reset_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |=> (!eoc_flag && !cal_busy));

endmodule

// File: tb/tb_adc_autocal.sv
module tb_adc_autocal;

    localparam int NUM_CH = 4;
    localparam int GAIN_W = 2;
    localparam int OFFS_W = 1;
    localparam int DATA_W = 12;
    localparam int KEY_W  = GAIN_W + OFFS_W;
    localparam int NKEY   = 1 << KEY_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_reset = 1'b0;
    logic cal_start = 1'b0;
    logic stat_read = 1'b0;
    logic eoc_irq_en = 1'b0;
    logic [NUM_CH-1:0] ch_enable = '0;
    logic [GAIN_W-1:0] gset [NUM_CH];
    logic [OFFS_W-1:0] oset [NUM_CH];
    logic [NUM_CH*GAIN_W-1:0] ch_gain;
    logic [NUM_CH*OFFS_W-1:0] ch_offs;
    logic cal_busy, eoc_flag, eoc_irq, meas_req, res_valid, res_uncal;
    logic [KEY_W-1:0] meas_key;
    logic meas_ack = 1'b0;
    logic [DATA_W-1:0] meas_corr = '0;
    logic conv_valid = 1'b0;
    logic [1:0] conv_ch = '0;
    logic [DATA_W-1:0] conv_raw = '0;
    logic [DATA_W-1:0] res_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Bench model of the table and the stub's correction words
    int stub_corr [NKEY];
    int model_corr [NKEY];
    bit model_valid [NKEY];
    int meas_log [$];
    logic [DATA_W:0] expq [$];
    string tagq [$];

    assign ch_gain = {gset[3], gset[2], gset[1], gset[0]};
    assign ch_offs = {oset[3], oset[2], oset[1], oset[0]};

    always #5 clk = ~clk;

    adc_autocal #(
        .NUM_CH (NUM_CH), .GAIN_W (GAIN_W), .OFFS_W (OFFS_W), .DATA_W (DATA_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .cal_start(cal_start),
        .stat_read(stat_read), .eoc_irq_en(eoc_irq_en), .ch_enable(ch_enable),
        .ch_gain(ch_gain), .ch_offs(ch_offs), .cal_busy(cal_busy), .eoc_flag(eoc_flag),
        .eoc_irq(eoc_irq), .meas_req(meas_req), .meas_key(meas_key), .meas_ack(meas_ack),
        .meas_corr(meas_corr), .conv_valid(conv_valid), .conv_ch(conv_ch),
        .conv_raw(conv_raw), .res_valid(res_valid), .res_data(res_data),
        .res_uncal(res_uncal)
    );

    function automatic int bkey(int ch);
        return (int'(gset[ch]) << OFFS_W) | int'(oset[ch]);
    endfunction

    function automatic int clampv(int v);
        if (v < 0) return 0;
        if (v > (1 << DATA_W) - 1) return (1 << DATA_W) - 1;
        return v;
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Measurement stub: answers a held request after two cycles
    initial begin
        forever begin
            @(negedge clk);
            if (meas_req && !meas_ack) begin
                int k;
                k = int'(meas_key);
                repeat (2) @(negedge clk);
                if (meas_req) begin
                    check("R2 key stable", int'(meas_key), k);
                    meas_ack  = 1'b1;
                    meas_corr = DATA_W'(stub_corr[k]);
                    meas_log.push_back(k);
                    model_corr[k]  = stub_corr[k];
                    model_valid[k] = 1'b1;
                    @(negedge clk);
                    meas_ack = 1'b0;
                end
            end
        end
    end

    // Driver: push the expected result and present one raw sample
    task automatic convert(string tag, int ch, int raw);
        int k;
        k = bkey(ch);
        if (model_valid[k]) expq.push_back({1'b0, DATA_W'(clampv(raw - model_corr[k]))});
        else                expq.push_back({1'b1, DATA_W'(raw)});
        tagq.push_back(tag);
        conv_valid = 1'b1;
        conv_ch    = 2'(ch);
        conv_raw   = DATA_W'(raw);
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    // Monitor: pop and compare each produced result
    initial begin
        forever begin
            @(negedge clk);
            if (res_valid) begin
                if (expq.size() == 0) begin
                    check("R11 unexpected result", 1, 0);
                end else begin
                    logic [DATA_W:0] e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check({t, " data"}, int'(res_data), int'(e[DATA_W-1:0]));
                    check({t, " uncal"}, int'(res_uncal), int'(e[DATA_W]));
                end
            end
        end
    end

    task automatic pulse_start();
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000; i++) begin
            if (!cal_busy) break;
            @(negedge clk);
        end
    endtask

    // Watchdog
    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < NKEY; k++) begin
            stub_corr[k] = k * 10;
            model_valid[k] = 1'b0;
            model_corr[k] = 0;
        end
        stub_corr[1] = -2048;
        stub_corr[2] = 100;
        // ch0,ch1 -> key 2; ch2 -> key 1; ch3 -> key 7
        gset[0] = 2'd1; oset[0] = 1'b0;
        gset[1] = 2'd1; oset[1] = 1'b0;
        gset[2] = 2'd0; oset[2] = 1'b1;
        gset[3] = 2'd3; oset[3] = 1'b1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 reset flag", int'(eoc_flag), 0);
        check("R5 reset irq", int'(eoc_irq), 0);
        check("R1 reset busy", int'(cal_busy), 0);
        check("R11 reset valid", int'(res_valid), 0);

        convert("R8 before calibration", 0, 1234);
        @(negedge clk);

        // First pass on channels 0..2, with mid-pass disturbances
        ch_enable = 4'b0111;
        meas_log.delete();
        pulse_start();
        check("R1 busy after start", int'(cal_busy), 1);
        ch_enable = 4'b1111;
        @(negedge clk);
        pulse_start();
        wait_idle();
        check("R2 request count", meas_log.size(), 2);
        if (meas_log.size() == 2) begin
            check("R2 first key ascending", meas_log[0], 1);
            check("R3 second key, key 7 absent", meas_log[1], 2);
        end
        repeat (8) @(negedge clk);
        check("R6 no restart after ignored start", int'(cal_busy), 0);
        check("R6 no extra requests", meas_log.size(), 2);
        check("R4 flag after pass", int'(eoc_flag), 1);
        check("R5 irq disabled", int'(eoc_irq), 0);
        eoc_irq_en = 1'b1;
        #1;
        check("R5 irq enabled", int'(eoc_irq), 1);
        @(negedge clk);
        stat_read = 1'b1;
        @(negedge clk);
        stat_read = 1'b0;
        check("R4 flag cleared by read", int'(eoc_flag), 0);
        check("R5 irq follows flag", int'(eoc_irq), 0);

        // Corrected results and clamps
        convert("R7 mid-range", 0, 1000);
        convert("R9 shared setting", 1, 2000);
        convert("R7 clamp low", 0, 50);
        convert("R7 clamp high", 2, 3000);
        convert("R8 uncalibrated key", 3, 777);
        @(negedge clk);
        gset[3] = 2'd0; oset[3] = 1'b1;
        convert("R9 moved to calibrated key", 3, 10);
        @(negedge clk);
        gset[3] = 2'd3; oset[3] = 1'b1;

        // Second pass over all channels: keys 1, 2, 7
        meas_log.delete();
        pulse_start();
        wait_idle();
        check("R2 second pass count", meas_log.size(), 3);
        if (meas_log.size() == 3) check("R2 third key", meas_log[2], 7);
        repeat (5) @(negedge clk);
        check("R4 flag sticky", int'(eoc_flag), 1);
        convert("R7 key 7", 3, 500);
        @(negedge clk);

        // Empty mask pass
        ch_enable = '0;
        stat_read = 1'b1;
        @(negedge clk);
        stat_read = 1'b0;
        meas_log.delete();
        pulse_start();
        wait_idle();
        @(negedge clk);
        check("R2 empty pass no requests", meas_log.size(), 0);
        check("R4 empty pass flag", int'(eoc_flag), 1);

        // Soft reset during a pending request
        ch_enable = 4'b1000;
        stub_corr[7] = 300;
        pulse_start();
        for (int i = 0; i < 20; i++) begin
            if (meas_req) break;
            @(negedge clk);
        end
        soft_reset = 1'b1;
        for (int k = 0; k < NKEY; k++) model_valid[k] = 1'b0;
        @(negedge clk);
        soft_reset = 1'b0;
        check("R10 busy after abort", int'(cal_busy), 0);
        check("R10 request dropped", int'(meas_req), 0);
        check("R10 flag cleared", int'(eoc_flag), 0);
        repeat (4) @(negedge clk);
        check("R10 no late completion", int'(eoc_flag), 0);
        convert("R10 entries dropped", 0, 1000);
        convert("R10 entries dropped key 7", 3, 900);
        repeat (3) @(negedge clk);
        check("R11 all results seen", expq.size(), 0);
        finish_run();
    end

endmodule